// File: doc/BRIEF.md
# MESI L1 Coherence Line Controller

This block holds the coherence state of every line of a small private L1 cache that sits below an inclusive shared L2 directory. Each cycle it may accept one classified event for one line: a CPU access, a replacement, an invalidate, a forwarded request, a data or ack response, or a writeback ack. Counting of outstanding acks and sorting of data responses into their kinds are done upstream. For the addressed line the block returns the current state, the access permission, the next state and a set of action strobes. The strobes tell the surrounding cache what to do: issue a request and which kind, send data or an ack, unblock the directory, complete a hit, manage the transaction buffer and the cache way, fill the line, and pop or recycle a queue.

The state table is indexed by line and reads without a clock. Outputs answer the event presented in the same cycle. The new state is written at the next rising clock edge, unless the event is illegal for the state. Eleven states are used: five stable and six transient. Among the transient states are a pending-shared state that has seen an invalidate race ahead of its data, and two replacing states that keep the evicted data so that they can still answer forwarded requests.

Top module: `l1_line_ctrl`

## Requirements
- R1: State codes are NP=0, I=1, S=2, E=3, M=4, IS=5, IM=6, SM=7, IS_I=8, M_I=9, E_I=10. Event codes are load=0, ifetch=1, store=2, replace=3, invalidate=4, fwd-GETX=5, fwd-GETS=6, fwd-GET_INSTR=7, data-with-acks-pending=8, exclusive-data=9, shared-data-from-peer=10, data-all-acks=11, ack=12, last-ack=13, writeback-ack=14; code 15 is reserved. After synchronous reset every line reads NP. While ev_valid is low, every strobe and err are 0 and nxt_state equals cur_state.
- R2: perm is a function of cur_state: 0 (invalid) for NP and I, 1 (read-only) for S and E, 2 (read-write) for M, and 3 (busy) for every transient state.
- R3: In any transient state, load, ifetch, store and replace raise only recycle_cpu and leave the state unchanged.
- R4: In NP or I, a load or ifetch goes to IS and a store goes to IM. Each of these raises way_alloc, buf_alloc, pop_cpu and req_valid, with req_kind GETS=0, GET_INSTR=1 or GETX=2. In S, E and M, a load or ifetch raises load_hit and pop_cpu. A store in E goes to M with store_hit and no request, and a store in M stays in M with store_hit. A store in S goes to SM with buf_alloc and an UPGRADE request (req_kind 3). Each serviced CPU event raises pop_cpu.
- R5: Replace in NP, I or S raises way_free and goes to NP. Replace in E goes to E_I and replace in M goes to M_I; both raise a PUTX request (req_kind 4), buf_alloc and way_free. No replace pops a queue.
- R6: In M_I or E_I, writeback-ack goes to I with buf_free and pop_resp. An invalidate sends buffered data to L2. A fwd-GETX sends buffered data to the requester. A fwd-GETS or fwd-GET_INSTR sends buffered data to both. Each of these goes to I with data_from_buf, buf_free and pop_fwd.
- R7: An invalidate in NP or I sends an ack and keeps the state. An invalidate in S or E sends an ack and goes to I. An invalidate in M sends data to L2 and goes to I. In E or M, a fwd-GETS or fwd-GET_INSTR sends data to the requester and to L2 and goes to S, and a fwd-GETX sends data to the requester only and goes to I. Each of these raises pop_fwd.
- R8: An invalidate in IS or IS_I sends an ack and goes to IS_I. Data-all-acks and shared-data-from-peer both raise fill_write, load_hit, buf_free and pop_resp; from IS they go to S and from IS_I they go to I. Only shared-data-from-peer also raises unblock. Exclusive-data in IS or IS_I goes to E with fill_write, load_hit, unblock_excl, buf_free and pop_resp.
- R9: An invalidate in IM or SM sends an ack and goes to IM. In IM, data-with-acks-pending goes to SM with fill_write and ack_update, and data-all-acks goes to M with fill_write, store_hit, unblock_excl and buf_free. An ack in IM or SM raises ack_update and keeps the state. A last-ack in SM goes to M with store_hit, unblock_excl and buf_free. All of these raise pop_resp, except the invalidates, which raise pop_fwd.
- R10: An event that R3 to R9 do not list for the current state, and code 15, raises err, raises no strobe, and leaves the line's state unchanged.
- R11: A legal event writes nxt_state into the addressed line at the next clock edge. No other line changes.
- R12: At most one of pop_cpu, pop_fwd, pop_resp and recycle_cpu is high in any cycle, and the one raised matches the queue the event came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_code | input | 4 | Event code (R1) |
| ev_line | input | IDX_W | Line index of the event; also selects which line cur_state shows |
| cur_state | output | 4 | Stored state of the addressed line |
| nxt_state | output | 4 | State after the presented event |
| perm | output | 2 | Access permission of the addressed line |
| err | output | 1 | Event is illegal in the current state |
| req_valid | output | 1 | Issue a request to L2 |
| req_kind | output | 3 | Request kind: GETS 0, GET_INSTR 1, GETX 2, UPGRADE 3, PUTX 4 |
| data_to_req | output | 1 | Send line data to the forwarding requester |
| data_to_l2 | output | 1 | Send line data to L2 |
| data_from_buf | output | 1 | Data comes from the transaction buffer |
| inv_ack | output | 1 | Send an invalidate ack |
| unblock | output | 1 | Send a plain unblock to the directory |
| unblock_excl | output | 1 | Send an exclusive unblock to the directory |
| load_hit | output | 1 | Complete a load or ifetch to the CPU |
| store_hit | output | 1 | Complete a store to the CPU |
| buf_alloc | output | 1 | Allocate a transaction buffer entry |
| buf_free | output | 1 | Free the transaction buffer entry |
| way_alloc | output | 1 | Allocate a cache way for the line |
| way_free | output | 1 | Free the cache way of the line |
| fill_write | output | 1 | Write response data into the line |
| ack_update | output | 1 | Subtract the response's ack count |
| pop_cpu | output | 1 | Pop the CPU queue |
| pop_fwd | output | 1 | Pop the forwarded-request queue |
| pop_resp | output | 1 | Pop the response queue |
| recycle_cpu | output | 1 | Move the CPU request to the back of its queue |

## Verification
The assertions check these rules on every cycle: transient states show busy permission, CPU events in transient states are recycled, a store in E completes silently, illegal events stay quiet, the state written back is the state that was reported, and the pop and recycle strobes and the two unblock kinds never overlap. Only the bench scenarios can show the full transition table. It brings each line into each of the eleven states along a legal path, applies every event code and compares the whole output bundle with its own model. It then reads the line back to confirm the state that was stored. A separate scenario checks that writing one line leaves another line untouched.

// File: rtl/mesi_l1_pkg.sv
`timescale 1ns/1ps
package mesi_l1_pkg;

    typedef enum logic [3:0] {
        ST_NP   = 4'd0,
        ST_I    = 4'd1,
        ST_S    = 4'd2,
        ST_E    = 4'd3,
        ST_M    = 4'd4,
        ST_IS   = 4'd5,
        ST_IM   = 4'd6,
        ST_SM   = 4'd7,
        ST_IS_I = 4'd8,
        ST_M_I  = 4'd9,
        ST_E_I  = 4'd10
    } line_st_t;

    typedef enum logic [3:0] {
        EV_LOAD      = 4'd0,
        EV_IFETCH    = 4'd1,
        EV_STORE     = 4'd2,
        EV_REPL      = 4'd3,
        EV_INV       = 4'd4,
        EV_FWD_GETX  = 4'd5,
        EV_FWD_GETS  = 4'd6,
        EV_FWD_GETI  = 4'd7,
        EV_DATA      = 4'd8,
        EV_DATA_EXCL = 4'd9,
        EV_DATA_PEER = 4'd10,
        EV_DATA_ALL  = 4'd11,
        EV_ACK       = 4'd12,
        EV_ACK_ALL   = 4'd13,
        EV_WB_ACK    = 4'd14
    } line_ev_t;

    typedef enum logic [1:0] {
        PM_NONE = 2'd0,
        PM_RO   = 2'd1,
        PM_RW   = 2'd2,
        PM_BUSY = 2'd3
    } perm_t;

    typedef enum logic [2:0] {
        RQ_GETS = 3'd0,
        RQ_GETI = 3'd1,
        RQ_GETX = 3'd2,
        RQ_UPG  = 3'd3,
        RQ_PUTX = 3'd4
    } req_kind_t;

    typedef struct packed {
        logic      req_valid;
        req_kind_t req_kind;
        logic      data_to_req;
        logic      data_to_l2;
        logic      data_from_buf;
        logic      inv_ack;
        logic      unblock;
        logic      unblock_excl;
        logic      load_hit;
        logic      store_hit;
        logic      buf_alloc;
        logic      buf_free;
        logic      way_alloc;
        logic      way_free;
        logic      fill_write;
        logic      ack_update;
        logic      pop_cpu;
        logic      pop_fwd;
        logic      pop_resp;
        logic      recycle_cpu;
    } strobes_t;

    localparam logic [3:0] EV_RESERVED = 4'd15;

    function automatic logic is_transient(line_st_t st);
        return (st == ST_IS) || (st == ST_IM) || (st == ST_SM) ||
               (st == ST_IS_I) || (st == ST_M_I) || (st == ST_E_I);
    endfunction

    function automatic logic is_cpu_ev(logic [3:0] ev);
        return (ev == EV_LOAD) || (ev == EV_IFETCH) ||
               (ev == EV_STORE) || (ev == EV_REPL);
    endfunction

    function automatic perm_t perm_of(line_st_t st);
        case (st)
            ST_NP, ST_I: return PM_NONE;
            ST_S, ST_E:  return PM_RO;
            ST_M:        return PM_RW;
            default:     return PM_BUSY;
        endcase
    endfunction

endpackage

// File: rtl/l1_state_table.sv
`timescale 1ns/1ps
module l1_state_table
    import mesi_l1_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_t         wr_state,
    input  logic [IDX_W-1:0] rd_idx,
    output line_st_t         rd_state
);

    line_st_t st_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g] <= ST_NP;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                st_q[g] <= wr_state;
            end
        end
    end

    assign rd_state = st_q[rd_idx];

endmodule

// File: rtl/l1_transition.sv
`timescale 1ns/1ps
module l1_transition
    import mesi_l1_pkg::*;
(
    input  logic       ev_valid,
    input  logic [3:0] ev_code,
    input  line_st_t   cur,
    output line_st_t   nxt,
    output strobes_t   act,
    output logic       err
);

    line_st_t nxt_raw;
    strobes_t act_raw;
    logic     legal;

    always_comb begin
        nxt_raw = cur;
        act_raw = '0;
        legal   = 1'b1;
        if (ev_code == EV_RESERVED) begin
            legal = 1'b0;
        end else if (is_transient(cur) && is_cpu_ev(ev_code)) begin
            act_raw.recycle_cpu = 1'b1;
        end else begin
            case (cur)
                ST_NP, ST_I: begin
                    case (ev_code)
                        EV_LOAD, EV_IFETCH, EV_STORE: begin
                            nxt_raw = (ev_code == EV_STORE) ? ST_IM : ST_IS;
                            act_raw.way_alloc = 1'b1;
                            act_raw.buf_alloc = 1'b1;
                            act_raw.req_valid = 1'b1;
                            act_raw.req_kind  = (ev_code == EV_LOAD)   ? RQ_GETS :
                                                (ev_code == EV_IFETCH) ? RQ_GETI : RQ_GETX;
                            act_raw.pop_cpu   = 1'b1;
                        end
                        EV_REPL: begin
                            nxt_raw = ST_NP;
                            act_raw.way_free = 1'b1;
                        end
                        EV_INV: begin
                            act_raw.inv_ack = 1'b1;
                            act_raw.pop_fwd = 1'b1;
                        end
                        default: legal = 1'b0;
                    endcase
                end
                ST_S: begin
                    case (ev_code)
                        EV_LOAD, EV_IFETCH: begin
                            act_raw.load_hit = 1'b1;
                            act_raw.pop_cpu  = 1'b1;
                        end
                        EV_STORE: begin
                            nxt_raw = ST_SM;
                            act_raw.buf_alloc = 1'b1;
                            act_raw.req_valid = 1'b1;
                            act_raw.req_kind  = RQ_UPG;
                            act_raw.pop_cpu   = 1'b1;
                        end
                        EV_REPL: begin
                            nxt_raw = ST_NP;
                            act_raw.way_free = 1'b1;
                        end
                        EV_INV: begin
                            nxt_raw = ST_I;
                            act_raw.inv_ack = 1'b1;
                            act_raw.pop_fwd = 1'b1;
                        end
                        default: legal = 1'b0;
                    endcase
                end
                ST_E, ST_M: begin
                    case (ev_code)
                        EV_LOAD, EV_IFETCH: begin
                            act_raw.load_hit = 1'b1;
                            act_raw.pop_cpu  = 1'b1;
                        end
                        EV_STORE: begin
                            nxt_raw = ST_M;
                            act_raw.store_hit = 1'b1;
                            act_raw.pop_cpu   = 1'b1;
                        end
                        EV_REPL: begin
                            nxt_raw = (cur == ST_E) ? ST_E_I : ST_M_I;
                            act_raw.buf_alloc = 1'b1;
                            act_raw.req_valid = 1'b1;
                            act_raw.req_kind  = RQ_PUTX;
                            act_raw.way_free  = 1'b1;
                        end
                        EV_INV: begin
                            nxt_raw = ST_I;
                            act_raw.inv_ack    = (cur == ST_E);
                            act_raw.data_to_l2 = (cur == ST_M);
                            act_raw.pop_fwd    = 1'b1;
                        end
                        EV_FWD_GETX: begin
                            nxt_raw = ST_I;
                            act_raw.data_to_req = 1'b1;
                            act_raw.pop_fwd     = 1'b1;
                        end
                        EV_FWD_GETS, EV_FWD_GETI: begin
                            nxt_raw = ST_S;
                            act_raw.data_to_req = 1'b1;
                            act_raw.data_to_l2  = 1'b1;
                            act_raw.pop_fwd     = 1'b1;
                        end
                        default: legal = 1'b0;
                    endcase
                end
                ST_M_I, ST_E_I: begin
                    case (ev_code)
                        EV_WB_ACK: begin
                            nxt_raw = ST_I;
                            act_raw.buf_free = 1'b1;
                            act_raw.pop_resp = 1'b1;
                        end
                        EV_INV, EV_FWD_GETX, EV_FWD_GETS, EV_FWD_GETI: begin
                            nxt_raw = ST_I;
                            act_raw.data_to_req   = (ev_code != EV_INV);
                            act_raw.data_to_l2    = (ev_code != EV_FWD_GETX);
                            act_raw.data_from_buf = 1'b1;
                            act_raw.buf_free      = 1'b1;
                            act_raw.pop_fwd       = 1'b1;
                        end
                        default: legal = 1'b0;
                    endcase
                end
                ST_IS, ST_IS_I: begin
                    case (ev_code)
                        EV_INV: begin
                            nxt_raw = ST_IS_I;
                            act_raw.inv_ack = 1'b1;
                            act_raw.pop_fwd = 1'b1;
                        end
                        EV_DATA_ALL, EV_DATA_PEER, EV_DATA_EXCL: begin
                            if (ev_code == EV_DATA_EXCL) begin
                                nxt_raw = ST_E;
                            end else begin
                                nxt_raw = (cur == ST_IS) ? ST_S : ST_I;
                            end
                            act_raw.fill_write   = 1'b1;
                            act_raw.load_hit     = 1'b1;
                            act_raw.unblock      = (ev_code == EV_DATA_PEER);
                            act_raw.unblock_excl = (ev_code == EV_DATA_EXCL);
                            act_raw.buf_free     = 1'b1;
                            act_raw.pop_resp     = 1'b1;
                        end
                        default: legal = 1'b0;
                    endcase
                end
                ST_IM, ST_SM: begin
                    case (ev_code)
                        EV_INV: begin
                            nxt_raw = ST_IM;
                            act_raw.inv_ack = 1'b1;
                            act_raw.pop_fwd = 1'b1;
                        end
                        EV_ACK: begin
                            act_raw.ack_update = 1'b1;
                            act_raw.pop_resp   = 1'b1;
                        end
                        EV_DATA: begin
                            if (cur == ST_IM) begin
                                nxt_raw = ST_SM;
                                act_raw.fill_write = 1'b1;
                                act_raw.ack_update = 1'b1;
                                act_raw.pop_resp   = 1'b1;
                            end else begin
                                legal = 1'b0;
                            end
                        end
                        EV_DATA_ALL, EV_ACK_ALL: begin
                            if ((cur == ST_IM) == (ev_code == EV_DATA_ALL)) begin
                                nxt_raw = ST_M;
                                act_raw.fill_write   = (ev_code == EV_DATA_ALL);
                                act_raw.store_hit    = 1'b1;
                                act_raw.unblock_excl = 1'b1;
                                act_raw.buf_free     = 1'b1;
                                act_raw.pop_resp     = 1'b1;
                            end else begin
                                legal = 1'b0;
                            end
                        end
                        default: legal = 1'b0;
                    endcase
                end
                default: legal = 1'b0;
            endcase
        end
    end

    always_comb begin
        if (ev_valid && legal) begin
            nxt = nxt_raw;
            act = act_raw;
        end else begin
            nxt = cur;
            act = '0;
        end
        err = ev_valid && !legal;
    end

endmodule

// File: rtl/l1_line_ctrl.sv
`timescale 1ns/1ps
module l1_line_ctrl
    import mesi_l1_pkg::*;
#(
    parameter  int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic [3:0]       ev_code,
    input  logic [IDX_W-1:0] ev_line,
    output logic [3:0]       cur_state,
    output logic [3:0]       nxt_state,
    output logic [1:0]       perm,
    output logic             err,
    output logic             req_valid,
    output logic [2:0]       req_kind,
    output logic             data_to_req,
    output logic             data_to_l2,
    output logic             data_from_buf,
    output logic             inv_ack,
    output logic             unblock,
    output logic             unblock_excl,
    output logic             load_hit,
    output logic             store_hit,
    output logic             buf_alloc,
    output logic             buf_free,
    output logic             way_alloc,
    output logic             way_free,
    output logic             fill_write,
    output logic             ack_update,
    output logic             pop_cpu,
    output logic             pop_fwd,
    output logic             pop_resp,
    output logic             recycle_cpu
);

    line_st_t rd_st;
    line_st_t nxt_st;
    strobes_t act;
    logic     err_w;

    l1_state_table #(.LINES(LINES), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ev_valid && !err_w),
        .wr_idx   (ev_line),
        .wr_state (nxt_st),
        .rd_idx   (ev_line),
        .rd_state (rd_st)
    );

    l1_transition u_trans (
        .ev_valid (ev_valid),
        .ev_code  (ev_code),
        .cur      (rd_st),
        .nxt      (nxt_st),
        .act      (act),
        .err      (err_w)
    );

    assign cur_state     = rd_st;
    assign nxt_state     = nxt_st;
    assign perm          = perm_of(rd_st);
    assign err           = err_w;
    assign req_valid     = act.req_valid;
    assign req_kind      = act.req_kind;
    assign data_to_req   = act.data_to_req;
    assign data_to_l2    = act.data_to_l2;
    assign data_from_buf = act.data_from_buf;
    assign inv_ack       = act.inv_ack;
    assign unblock       = act.unblock;
    assign unblock_excl  = act.unblock_excl;
    assign load_hit      = act.load_hit;
    assign store_hit     = act.store_hit;
    assign buf_alloc     = act.buf_alloc;
    assign buf_free      = act.buf_free;
    assign way_alloc     = act.way_alloc;
    assign way_free      = act.way_free;
    assign fill_write    = act.fill_write;
    assign ack_update    = act.ack_update;
    assign pop_cpu       = act.pop_cpu;
    assign pop_fwd       = act.pop_fwd;
    assign pop_resp      = act.pop_resp;
    assign recycle_cpu   = act.recycle_cpu;

endmodule

// File: rtl/l1_line_ctrl_chk.sv
`timescale 1ns/1ps
module l1_line_ctrl_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_valid,
    input logic [3:0]       ev_code,
    input logic [IDX_W-1:0] ev_line,
    input logic [3:0]       cur_state,
    input logic [3:0]       nxt_state,
    input logic [1:0]       perm,
    input logic             err,
    input logic             req_valid,
    input logic             unblock,
    input logic             unblock_excl,
    input logic             store_hit,
    input logic             buf_alloc,
    input logic             buf_free,
    input logic             pop_cpu,
    input logic             pop_fwd,
    input logic             pop_resp,
    input logic             recycle_cpu
);

    p_perm_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (cur_state >= 4'd5) |-> (perm == 2'd3));

    p_recycle_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && cur_state >= 4'd5 && ev_code <= 4'd3)
        |-> (recycle_cpu && !pop_cpu && !req_valid && nxt_state == cur_state));

    p_silent_store_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && cur_state == 4'd3 && ev_code == 4'd2)
        |-> (nxt_state == 4'd4 && store_hit && !req_valid));

    p_buf_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({buf_alloc, buf_free}));

    p_unblock_kind_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({unblock, unblock_excl}));

    p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && err) |-> (nxt_state == cur_state && !req_valid && !pop_cpu &&
                               !pop_fwd && !pop_resp && !recycle_cpu &&
                               !buf_alloc && !buf_free));

    p_err_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && err) |=> ((ev_line != $past(ev_line)) ||
                               (cur_state == $past(cur_state))));

    p_write_back_r11: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !err) |=> ((ev_line != $past(ev_line)) ||
                                (cur_state == $past(nxt_state))));

    p_one_queue_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pop_cpu, pop_fwd, pop_resp, recycle_cpu}));

endmodule

bind l1_line_ctrl l1_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_valid     (ev_valid),
    .ev_code      (ev_code),
    .ev_line      (ev_line),
    .cur_state    (cur_state),
    .nxt_state    (nxt_state),
    .perm         (perm),
    .err          (err),
    .req_valid    (req_valid),
    .unblock      (unblock),
    .unblock_excl (unblock_excl),
    .store_hit    (store_hit),
    .buf_alloc    (buf_alloc),
    .buf_free     (buf_free),
    .pop_cpu      (pop_cpu),
    .pop_fwd      (pop_fwd),
    .pop_resp     (pop_resp),
    .recycle_cpu  (recycle_cpu)
);

// File: tb/test_l1_line_ctrl.sv
`timescale 1ns/1ps
module test_l1_line_ctrl;

    localparam int LINES = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_valid = 1'b0;
    logic [3:0] ev_code = 4'd0;
    logic [3:0] ev_line = 4'd0;
    logic [3:0] cur_state, nxt_state;
    logic [1:0] perm;
    logic       err, req_valid;
    logic [2:0] req_kind;
    logic       data_to_req, data_to_l2, data_from_buf, inv_ack, unblock, unblock_excl;
    logic       load_hit, store_hit, buf_alloc, buf_free, way_alloc, way_free;
    logic       fill_write, ack_update, pop_cpu, pop_fwd, pop_resp, recycle_cpu;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    l1_line_ctrl #(.LINES(LINES)) i_l1_line_ctrl (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code), .ev_line(ev_line),
        .cur_state(cur_state), .nxt_state(nxt_state), .perm(perm), .err(err),
        .req_valid(req_valid), .req_kind(req_kind), .data_to_req(data_to_req),
        .data_to_l2(data_to_l2), .data_from_buf(data_from_buf), .inv_ack(inv_ack),
        .unblock(unblock), .unblock_excl(unblock_excl), .load_hit(load_hit),
        .store_hit(store_hit), .buf_alloc(buf_alloc), .buf_free(buf_free),
        .way_alloc(way_alloc), .way_free(way_free), .fill_write(fill_write),
        .ack_update(ack_update), .pop_cpu(pop_cpu), .pop_fwd(pop_fwd),
        .pop_resp(pop_resp), .recycle_cpu(recycle_cpu)
    );

    // nxt(4) err rv kind(3) dr dl db ak ub ux lh sh ba bf wa wf fw au pc pf pr rc
    function automatic logic [26:0] actual_bundle();
        return {nxt_state, err, req_valid, req_kind, data_to_req, data_to_l2, data_from_buf,
                inv_ack, unblock, unblock_excl, load_hit, store_hit, buf_alloc, buf_free,
                way_alloc, way_free, fill_write, ack_update, pop_cpu, pop_fwd, pop_resp,
                recycle_cpu};
    endfunction

    function automatic logic [26:0] model(int s, int e);
        logic [3:0] n;
        logic er, rv;
        logic [2:0] rk;
        logic dr, dl, db, ak, ub, ux, lh, sh, ba, bf, wa, wf, fw, au, pc, pf, pr, rc;
        n = 4'(s); er = 0; rv = 0; rk = 3'd0;
        {dr, dl, db, ak, ub, ux, lh, sh, ba, bf, wa, wf, fw, au, pc, pf, pr, rc} = '0;
        if (e == 15) er = 1;
        else if (s >= 5 && e <= 3) rc = 1;
        else begin
            case (s)
                0, 1: case (e)
                    0, 1, 2: begin
                        n = (e == 2) ? 4'd6 : 4'd5;
                        wa = 1; ba = 1; rv = 1; rk = 3'(e); pc = 1;
                    end
                    3: begin n = 0; wf = 1; end
                    4: begin ak = 1; pf = 1; end
                    default: er = 1;
                endcase
                2: case (e)
                    0, 1: begin lh = 1; pc = 1; end
                    2: begin n = 7; ba = 1; rv = 1; rk = 3; pc = 1; end
                    3: begin n = 0; wf = 1; end
                    4: begin n = 1; ak = 1; pf = 1; end
                    default: er = 1;
                endcase
                3, 4: case (e)
                    0, 1: begin lh = 1; pc = 1; end
                    2: begin n = 4; sh = 1; pc = 1; end
                    3: begin n = (s == 3) ? 4'd10 : 4'd9; ba = 1; rv = 1; rk = 4; wf = 1; end
                    4: begin n = 1; if (s == 4) dl = 1; else ak = 1; pf = 1; end
                    5: begin n = 1; dr = 1; pf = 1; end
                    6, 7: begin n = 2; dr = 1; dl = 1; pf = 1; end
                    default: er = 1;
                endcase
                9, 10: case (e)
                    14: begin n = 1; bf = 1; pr = 1; end
                    4: begin n = 1; dl = 1; db = 1; bf = 1; pf = 1; end
                    5: begin n = 1; dr = 1; db = 1; bf = 1; pf = 1; end
                    6, 7: begin n = 1; dr = 1; dl = 1; db = 1; bf = 1; pf = 1; end
                    default: er = 1;
                endcase
                5, 8: case (e)
                    4: begin n = 8; ak = 1; pf = 1; end
                    10, 11: begin
                        n = (s == 5) ? 4'd2 : 4'd1;
                        fw = 1; lh = 1; bf = 1; pr = 1; ub = (e == 10);
                    end
                    9: begin n = 3; fw = 1; lh = 1; ux = 1; bf = 1; pr = 1; end
                    default: er = 1;
                endcase
                6, 7: case (e)
                    4: begin n = 6; ak = 1; pf = 1; end
                    12: begin au = 1; pr = 1; end
                    8: if (s == 6) begin n = 7; fw = 1; au = 1; pr = 1; end else er = 1;
                    11: if (s == 6) begin n = 4; fw = 1; sh = 1; ux = 1; bf = 1; pr = 1; end
                        else er = 1;
                    13: if (s == 7) begin n = 4; sh = 1; ux = 1; bf = 1; pr = 1; end
                        else er = 1;
                    default: er = 1;
                endcase
                default: er = 1;
            endcase
        end
        if (er) begin
            n = 4'(s); rv = 0; rk = 0;
            {dr, dl, db, ak, ub, ux, lh, sh, ba, bf, wa, wf, fw, au, pc, pf, pr, rc} = '0;
        end
        return {n, er, rv, rk, dr, dl, db, ak, ub, ux, lh, sh, ba, bf, wa, wf, fw, au,
                pc, pf, pr, rc};
    endfunction

    function automatic string tag_of(int s, int e);
        logic [26:0] m;
        m = model(s, e);
        if (m[22]) return "R10";
        if (s >= 5 && e <= 3) return "R3";
        if (e == 3) return "R5";
        if (s == 9 || s == 10) return "R6";
        if (e <= 2) return "R4";
        if (s <= 4) return "R7";
        if (s == 5 || s == 8) return "R8";
        return "R9";
    endfunction

    function automatic logic [1:0] perm_exp(int s);
        if (s <= 1) return 2'd0;
        if (s <= 3) return 2'd1;
        if (s == 4) return 2'd2;
        return 2'd3;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act_v, logic [31:0] exp_v, string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act_v, exp_v);
        end
    endtask

    task automatic drive(int e, int line);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_code  = 4'(e);
        ev_line  = 4'(line);
        #1;
    endtask

    task automatic idle(int line);
        @(negedge clk);
        ev_valid = 1'b0;
        ev_line  = 4'(line);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ev_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic walk_to(int s, int line);
        case (s)
            1:  begin drive(0, line); drive(4, line); drive(11, line); end
            2:  begin drive(0, line); drive(11, line); end
            3:  begin drive(0, line); drive(9, line); end
            4:  begin drive(2, line); drive(11, line); end
            5:  drive(0, line);
            6:  drive(2, line);
            7:  begin drive(0, line); drive(11, line); drive(2, line); end
            8:  begin drive(0, line); drive(4, line); end
            9:  begin drive(2, line); drive(11, line); drive(3, line); end
            10: begin drive(0, line); drive(9, line); drive(3, line); end
            default: ;
        endcase
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [26:0] exp_b;
        logic [26:0] act_b;
        do_reset();

        // R1: reset state of every line and quiet idle outputs
        for (int l = 0; l < LINES; l++) begin
            idle(l);
            act_b = actual_bundle();
            check(cur_state == 4'd0 && perm == 2'd0 && act_b == {4'd0, 23'd0}, "R1",
                  {cur_state, perm, act_b}, {4'd0, 2'd0, 27'd0}, "reset line");
        end

        // Sweep: every state x every event code
        for (int s = 0; s < 11; s++) begin
            for (int e = 0; e < 16; e++) begin
                int line;
                string tg;
                line = (s * 5 + e) % LINES;
                tg = tag_of(s, e);
                do_reset();
                walk_to(s, line);
                drive(e, line);
                check(cur_state == 4'(s), "R11", cur_state, s, "walk reached state");
                check(perm == perm_exp(s), "R2", perm, perm_exp(s), "permission");
                exp_b = model(s, e);
                act_b = actual_bundle();
                check(act_b == exp_b, tg, act_b, exp_b, $sformatf("bundle s=%0d e=%0d", s, e));
                check(act_b[3:0] == exp_b[3:0], "R12", act_b[3:0], exp_b[3:0], "queue strobes");
                idle(line);
                check(cur_state == exp_b[26:23], exp_b[22] ? "R10" : "R11",
                      cur_state, exp_b[26:23], $sformatf("stored s=%0d e=%0d", s, e));
            end
        end

        // R11: another line stays untouched
        do_reset();
        drive(2, 2);
        drive(11, 2);
        drive(0, 7);
        idle(2);
        check(cur_state == 4'd4, "R11", cur_state, 4, "line 2 in M");
        idle(7);
        check(cur_state == 4'd5, "R11", cur_state, 5, "line 7 in IS");
        idle(9);
        check(cur_state == 4'd0, "R11", cur_state, 0, "line 9 untouched");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule